// File: doc/BRIEF.md
# Chip-Select Window Address Decoder

This block turns a 32-bit system-bus address into one of eight chip selects. Each bank owns one 32-bit configuration word that software writes and reads through a simple register port. The word holds a window base, a compare mask and an enable bit. Every address is compared against all eight windows at 128 KiB granularity. The block raises one one-hot chip select and a hit flag, and the decode is purely combinational.

Banks 0 and 1 are the boot banks. They decode whatever the state of their enable bit. With an all-zero word, a boot bank answers every address. Writing all ones into an unused boot bank parks it on the topmost 128 KiB window, which frees the rest of the map.

A strap input is captured during reset. When it is set, the chip select outputs of bank 0 and bank 1 are exchanged. The bank 0 word then comes out of reset with its enable bit clear, and software reads that bit to detect the swap.

Top module: `cs_window_decoder`

## Requirements
- R1: A write with `reg_we_i` high to byte offset 0x100 + 0x10·n (n = 0..7) replaces bank n's word at the next clock edge. `reg_rdata_o` returns the addressed word combinationally. Any other offset reads as zero, and a write to it changes no bank word and no decode result.
- R2: During reset, bank 0's word loads 0x00000001 when the strap is low and 0x00000000 when it is high. Banks 1 to 7 load zero.
- R3: Word bits [31:17] hold the window base for address bits [31:17]. Word bit k, for k = 1..15, is the compare mask for address bit k+16. A mask bit of 1 requires the address bit to equal the base bit, and a mask bit of 0 ignores that address bit. Address bits [16:0] never affect the decode.
- R4: A bank numbered 2 to 7 whose word bit 0 (enable) is 0 never drives its chip select.
- R5: Banks 0 and 1 decode whatever the value of word bit 0. A boot-bank word of all zeros matches every address.
- R6: A boot-bank word of 0xFFFFFFFF matches only addresses whose bits [31:17] are all ones.
- R7: When several banks match, only the lowest-numbered matching bank drives its chip select, so `cs_o` is one-hot. `hit_o` is high exactly when `cs_o` is non-zero.
- R8: With the strap captured high at reset, bank 0's match drives `cs_o[1]` and bank 1's match drives `cs_o[0]`. Changing the strap after reset has no effect until the next reset.
- R9: When no bank matches, `cs_o` is all zeros and `hit_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_swap_i | input | 1 | Strap captured during reset; swaps chip selects 0 and 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| bus_addr_i | input | 32 | Bus address to decode |
| cs_o | output | 8 | One-hot chip selects |
| hit_o | output | 1 | High when any bank claims the address |

## Verification
The assertions assume three things about the inputs:
- the strap is meaningful only while reset is held;
- the register strobe is a level that is sampled once per clock;
- the bus address may change at any time, because decode has no state.

The bench follows these assumptions. It changes the strap only between resets, except for one deliberate change after reset that tests R8. It drives the write strobe, register offset and bus address on the falling edge, and it compares the outputs shortly after that edge, once the combinational decode has settled.

// File: rtl/cswd_pkg.sv
// Shared types and the window compare function for the chip-select decoder.
// Assumes a 32-bit address and a 128 KiB window granule (address bits [16:0] unused).
package cswd_pkg;
    localparam int WORD_W  = 32;
    localparam int GRAN_LSB = 17;
    localparam int CMP_W   = WORD_W - GRAN_LSB;

    typedef logic [WORD_W-1:0] cfg_word_t;

    // True when the address falls inside the window described by cfg.
    // Mask bit k of the word (k = 1..15) covers address bit k+16.
    function automatic logic window_match(input logic [WORD_W-1:0] addr,
                                          input cfg_word_t cfg);
        logic [CMP_W-1:0] diff;
        diff = addr[WORD_W-1:GRAN_LSB] ^ cfg[WORD_W-1:GRAN_LSB];
        return (diff & cfg[CMP_W:1]) == '0;
    endfunction
endpackage

// File: rtl/cswd_regfile.sv
// Bank configuration words, the register port and the reset-time strap capture.
// Assumes byte offsets; bank n sits at BASE_OFS + STRIDE*n. Unmapped offsets
// read zero and ignore writes.
module cswd_regfile #(
    parameter int NUM_BANKS = 8,
    parameter int REG_AW    = 12,
    parameter int BASE_OFS  = 'h100,
    parameter int STRIDE    = 'h10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strap_i,
    input  logic                 we_i,
    input  logic [REG_AW-1:0]    addr_i,
    input  cswd_pkg::cfg_word_t  wdata_i,
    output cswd_pkg::cfg_word_t  rdata_o,
    output cswd_pkg::cfg_word_t  cfg_o [NUM_BANKS],
    output logic                 swap_o
);
    import cswd_pkg::*;

    logic [NUM_BANKS-1:0] sel;
    cfg_word_t            cfg_q [NUM_BANKS];
    logic                 swap_q;

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_bank
        localparam logic [REG_AW-1:0] OFS = REG_AW'(BASE_OFS + STRIDE * n);
        assign sel[n] = (addr_i == OFS);

        if (n == 0) begin : g_boot0
            // Bank 0 word: reset value reports the strap through the enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n)                cfg_q[n] <= {{(WORD_W-1){1'b0}}, ~strap_i};
                else if (we_i && sel[n])   cfg_q[n] <= wdata_i;
            end
        end else begin : g_other
            // Other bank words: cleared at reset, loaded on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)                cfg_q[n] <= '0;
                else if (we_i && sel[n])   cfg_q[n] <= wdata_i;
            end
        end

        assign cfg_o[n] = cfg_q[n];

        assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && sel[n]) |=> (cfg_q[n] == $past(wdata_i)));
        assert_no_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && sel[n]) |=> $stable(cfg_q[n]));
    end

    // Strap capture: follows the strap only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) swap_q <= strap_i;
    end

    // Readback mux: OR of the addressed word (at most one select is set).
    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NUM_BANKS; n++)
            rdata_o = rdata_o | ({WORD_W{sel[n]}} & cfg_q[n]);
    end

    assign swap_o = swap_q;

    assert_strap_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(swap_q));
endmodule

// File: rtl/cswd_bank_match.sv
// Per-bank window compare. Assumes the first ALWAYS_ON banks ignore their
// enable bit (boot banks); the rest need word bit 0 set to match.
module cswd_bank_match #(
    parameter int NUM_BANKS = 8,
    parameter int ALWAYS_ON = 2
) (
    input  logic [cswd_pkg::WORD_W-1:0] addr_i,
    input  cswd_pkg::cfg_word_t         cfg_i [NUM_BANKS],
    output logic [NUM_BANKS-1:0]        match_o
);
    import cswd_pkg::*;

    for (genvar n = 0; n < NUM_BANKS; n++) begin : g_cmp
        if (n < ALWAYS_ON) begin : g_boot
            // Boot bank: always active.
            assign match_o[n] = window_match(addr_i, cfg_i[n]);
        end else begin : g_gated
            // Ordinary bank: gated by the enable bit.
            assign match_o[n] = cfg_i[n][0] & window_match(addr_i, cfg_i[n]);
        end
    end
endmodule

// File: rtl/cswd_pick_swap.sv
// Lowest-index priority pick followed by the optional exchange of outputs 0 and 1.
// Assumes NUM_BANKS >= 2.
module cswd_pick_swap #(
    parameter int NUM_BANKS = 8
) (
    input  logic [NUM_BANKS-1:0] match_i,
    input  logic                 swap_i,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic                 hit_o
);
    logic [NUM_BANKS-1:0] grant;

    // Isolate the lowest set bit of the match vector.
    assign grant = match_i & (~match_i + NUM_BANKS'(1));

    assign cs_o[0] = swap_i ? grant[1] : grant[0];
    assign cs_o[1] = swap_i ? grant[0] : grant[1];
    if (NUM_BANKS > 2) begin : g_upper
        assign cs_o[NUM_BANKS-1:2] = grant[NUM_BANKS-1:2];
    end

    assign hit_o = |match_i;
endmodule

// File: rtl/cs_window_decoder.sv
// Top of the chip-select window decoder: register file, per-bank compare and
// priority/swap output stage. Decode is combinational from bus_addr_i and the
// stored words; register writes land on the next clock edge.
module cs_window_decoder #(
    parameter int NUM_BANKS = 8,
    parameter int REG_AW    = 12,
    parameter int BASE_OFS  = 'h100,
    parameter int STRIDE    = 'h10,
    parameter int ALWAYS_ON = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 boot_swap_i,
    input  logic                 reg_we_i,
    input  logic [REG_AW-1:0]    reg_addr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic [31:0]          bus_addr_i,
    output logic [NUM_BANKS-1:0] cs_o,
    output logic                 hit_o
);
    import cswd_pkg::*;

    cfg_word_t            cfg [NUM_BANKS];
    logic                 swap;
    logic [NUM_BANKS-1:0] match;

    cswd_regfile #(
        .NUM_BANKS(NUM_BANKS), .REG_AW(REG_AW),
        .BASE_OFS(BASE_OFS), .STRIDE(STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .strap_i(boot_swap_i),
        .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
        .rdata_o(reg_rdata_o), .cfg_o(cfg), .swap_o(swap)
    );

    cswd_bank_match #(.NUM_BANKS(NUM_BANKS), .ALWAYS_ON(ALWAYS_ON)) u_match (
        .addr_i(bus_addr_i), .cfg_i(cfg), .match_o(match)
    );

    cswd_pick_swap #(.NUM_BANKS(NUM_BANKS)) u_pick (
        .match_i(match), .swap_i(swap), .cs_o(cs_o), .hit_o(hit_o)
    );

    assert_onehot_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));
    assert_hit_matches_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o == (cs_o != '0));
    assert_boot_catchall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg[0] == '0) |-> (swap ? cs_o[1] : cs_o[0]));

    for (genvar n = ALWAYS_ON; n < NUM_BANKS; n++) begin : g_off_chk
        assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[n][0] |-> !cs_o[n]);
    end
endmodule

// File: tb/cs_window_decoder_tb_top.sv
module cs_window_decoder_tb_top;
    localparam time CLK_P = 10ns;
    localparam int  NB    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_swap_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic [11:0] reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [31:0] bus_addr_i = '0;
    logic [NB-1:0] cs_o;
    logic        hit_o;

    cs_window_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .boot_swap_i(boot_swap_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .bus_addr_i(bus_addr_i),
        .cs_o(cs_o), .hit_o(hit_o)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        logic [NB-1:0] cs;
        logic          hit;
        string         tag;
    } exp_t;

    exp_t exp_q [$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Register-side check: combinational readback after the offset settles.
    task automatic rd(input logic [11:0] ofs, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr_i = ofs;
        #1;
        checks++;
        if (reg_rdata_o !== exp) begin
            fails++;
            $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h", tag, ofs, reg_rdata_o, exp);
        end
    endtask

    task automatic wr(input logic [11:0] ofs, input logic [31:0] data);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = ofs; reg_wdata_i = data;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    // Driver: applies an address and queues the expected decode.
    task automatic probe(input logic [31:0] a, input logic [NB-1:0] cs, input string tag);
        exp_t e;
        @(negedge clk);
        bus_addr_i = a;
        e.cs = cs; e.hit = (cs != '0); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        boot_swap_i = strap;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: pops expected decodes and compares them once outputs settle.
    always @(negedge clk) begin
        #1;
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cs_o !== e.cs || hit_o !== e.hit) begin
                fails++;
                $display("FAIL %s: addr 0x%08h cs=%b hit=%b expected cs=%b hit=%b",
                         e.tag, bus_addr_i, cs_o, hit_o, e.cs, e.hit);
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        report();
    end

    initial begin
        // Phase A: strap low
        do_reset(1'b0);
        rd(12'h100, 32'h0000_0001, "R2 bank0 reset strap low");
        rd(12'h130, 32'h0, "R2 bank3 reset");
        rd(12'h000, 32'h0, "R1 unmapped read");
        probe(32'h1234_5678, 8'h01, "R5 bank0 enabled zero window");

        wr(12'h100, 32'hFFFF_FFFF);
        rd(12'h100, 32'hFFFF_FFFF, "R1 readback bank0");
        probe(32'h1234_5678, 8'h02, "R5 bank1 zero word catch-all with enable clear");

        wr(12'h110, 32'hFFFF_FFFF);
        probe(32'h1234_5678, 8'h00, "R9 no bank matches");
        probe(32'hFFFE_0000, 8'h01, "R6 R7 top window lowest bank wins");
        probe(32'hFFFF_FFFF, 8'h01, "R6 top window end");
        probe(32'hFFFD_FFFF, 8'h00, "R6 just below top window");

        wr(12'h130, 32'h4000_FF00);
        probe(32'h4000_1000, 8'h00, "R4 bank3 disabled");

        wr(12'h130, 32'h4000_FF01);
        probe(32'h40AB_CDEF, 8'h08, "R3 bank3 16MiB window");
        probe(32'h4000_0000, 8'h08, "R3 window start");
        probe(32'h4001_FFFF, 8'h08, "R3 low bits ignored");
        probe(32'h4100_0000, 8'h00, "R3 masked bit differs");

        wr(12'h150, 32'h4000_F001);
        rd(12'h150, 32'h4000_F001, "R1 readback bank5");
        probe(32'h4012_3456, 8'h08, "R7 overlap bank3 over bank5");
        probe(32'h4800_0000, 8'h20, "R3 unmasked bit ignored bank5");
        probe(32'h5000_0000, 8'h00, "R9 miss all windows");

        wr(12'h104, 32'hDEAD_BEEF);
        rd(12'h104, 32'h0, "R1 unmapped write ignored");
        rd(12'h100, 32'hFFFF_FFFF, "R1 bank0 untouched by stray write");
        probe(32'h4012_3456, 8'h08, "R1 decode unchanged by stray write");

        wr(12'h110, 32'h0);
        probe(32'h4012_3456, 8'h02, "R5 bank1 catch-all beats upper banks");

        // Phase B: strap high
        do_reset(1'b1);
        rd(12'h100, 32'h0, "R2 bank0 reset strap high");
        rd(12'h150, 32'h0, "R2 bank5 cleared by reset");
        probe(32'h0000_1000, 8'h02, "R8 bank0 drives cs1");

        wr(12'h100, 32'hFFFF_FFFF);
        probe(32'h0000_1000, 8'h01, "R8 bank1 drives cs0");
        @(negedge clk);
        boot_swap_i = 1'b0;
        probe(32'h0000_1000, 8'h01, "R8 strap change after reset ignored");
        probe(32'hFFFE_0000, 8'h02, "R8 R7 bank0 priority on swapped output");

        repeat (3) @(negedge clk);
        report();
    end
endmodule